// File: doc/BRIEF.md
# Serial ADC Convert-and-Readout Controller

This block runs a serial analog-to-digital converter from the host side over three wires: a convert line that it drives, a serial clock that it generates, and the converter's serial data line that it reads. A start request raises the convert line. The line is held high for a programmable number of system clock cycles, long enough to cover the worst-case conversion. The controller then drops the line, and the converter presents its most significant bit. After a programmable settle delay the controller captures that bit. It then issues one fewer serial clock pulse than the result has bits and captures one further bit per pulse.

Each bit is sampled one half-period after the falling clock edge that shifted it out, which is the moment a following rising edge would occur. The assembled word is presented on a parallel output with a one-cycle done pulse. Between conversions the convert line stays low and the serial clock stays idle, so start requests may be any distance apart.

Top module: `adcrd_host`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) leaves `cnvOut`, `sclkOut`, `busy` and `done` low and `result` all zeros.
- R2: A `startReq` sampled high while idle sets `cnvOut` and `busy` high from the next cycle on, and `cnvOut` then stays high for exactly `CONV_CYC` cycles.
- R3: After `cnvOut` falls, `sclkOut` stays low for exactly `SETTLE_CYC` cycles. The most significant bit is sampled from `sdoIn` at the end of that window.
- R4: Each conversion produces exactly `DATA_W-1` serial clock pulses. Each pulse is high for `HALF_CYC` cycles, and consecutive pulses are separated by `HALF_CYC` low cycles. `sclkOut` idles low.
- R5: Every further bit is sampled `HALF_CYC` cycles after a falling `sclkOut` edge. `result` holds the bits most significant first, so bit `DATA_W-1` is the one presented when `cnvOut` fell.
- R6: `done` is high for exactly one cycle per conversion, with the new `result` valid in that cycle. `busy` is low from that cycle on, and `result` holds its value until the next `done` or reset.
- R7: A `startReq` that arrives while `busy` is high is ignored. It causes no extra rise of `cnvOut` and does not change the running conversion's timing or result.
- R8: After a readout, `cnvOut` and `sclkOut` stay low for as long as no new start arrives, and a start after an arbitrarily long idle gap converts normally.
- R9: A reset asserted in the middle of a conversion returns the controller to the R1 state, clearing a previously held `result`, and the next start converts normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Request to start one conversion |
| sdoIn | input | 1 | Serial data from the converter |
| cnvOut | output | 1 | Convert line to the converter |
| sclkOut | output | 1 | Generated serial clock, idles low |
| busy | output | 1 | High from accepted start until done |
| done | output | 1 | One-cycle pulse marking a valid result |
| result | output | DATA_W | Assembled conversion word |

## Verification
The bench builds the block with a 6-bit result, a 5-cycle convert hold, a 2-cycle settle delay and a 2-cycle serial clock half-period. At this size all 64 output codes can be swept through a behavioural converter model in a few thousand cycles. Each conversion has its convert-high length, settle gap, pulse count and every high and low width measured against the parameters. The short timings also leave room to inject starts during both the conversion and the shift phase, to add a 2000-cycle idle gap, and to apply a reset in the middle of a shift.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CONV   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_SHIFT  = 2'd3
  } ctrlState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic capMsb;   // load first bit into the shift register
    logic capBit;   // shift in one further bit
    logic finish;   // last bit: publish the word and pulse done
  } dpStrobe_t;

endpackage

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CONV_CYC   = 400,
  parameter int SETTLE_CYC = 2,
  parameter int HALF_CYC   = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      startReq,
  output logic      cnvOut,
  output logic      sclkOut,
  output logic      busy,
  output dpStrobe_t strb
);

  localparam int TMR_MAX_A = (CONV_CYC > SETTLE_CYC) ? CONV_CYC : SETTLE_CYC;
  localparam int TMR_MAX   = (TMR_MAX_A > HALF_CYC) ? TMR_MAX_A : HALF_CYC;
  localparam int TMR_W     = $clog2(TMR_MAX + 1);
  localparam int BIT_W     = $clog2(DATA_W);

  localparam logic [TMR_W-1:0] CONV_END   = TMR_W'(CONV_CYC - 1);
  localparam logic [TMR_W-1:0] SETTLE_END = TMR_W'(SETTLE_CYC - 1);
  localparam logic [TMR_W-1:0] HALF_END   = TMR_W'(HALF_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(DATA_W - 2);

  ctrlState_t       state, stateNxt;
  logic [TMR_W-1:0] tmr, tmrNxt;
  logic [BIT_W-1:0] bitCnt, bitCntNxt;
  logic             cnvReg, cnvNxt;
  logic             sclkReg, sclkNxt;
  logic             busyReg, busyNxt;

  always_comb begin
    stateNxt  = state;
    tmrNxt    = tmr;
    bitCntNxt = bitCnt;
    cnvNxt    = cnvReg;
    sclkNxt   = sclkReg;
    busyNxt   = busyReg;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          stateNxt = ST_CONV;
          tmrNxt   = '0;
          cnvNxt   = 1'b1;
          busyNxt  = 1'b1;
        end
      end
      ST_CONV: begin
        if (tmr == CONV_END) begin
          stateNxt = ST_SETTLE;
          tmrNxt   = '0;
          cnvNxt   = 1'b0;
        end else begin
          tmrNxt = tmr + 1'b1;
        end
      end
      ST_SETTLE: begin
        if (tmr == SETTLE_END) begin
          strb.capMsb = 1'b1;
          stateNxt    = ST_SHIFT;
          tmrNxt      = '0;
          bitCntNxt   = '0;
          sclkNxt     = 1'b1;
        end else begin
          tmrNxt = tmr + 1'b1;
        end
      end
      ST_SHIFT: begin
        if (tmr == HALF_END) begin
          tmrNxt = '0;
          if (sclkReg) begin
            sclkNxt = 1'b0;
          end else begin
            strb.capBit = 1'b1;
            if (bitCnt == LAST_BIT) begin
              strb.finish = 1'b1;
              stateNxt    = ST_IDLE;
              busyNxt     = 1'b0;
            end else begin
              bitCntNxt = bitCnt + 1'b1;
              sclkNxt   = 1'b1;
            end
          end
        end else begin
          tmrNxt = tmr + 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      tmr     <= '0;
      bitCnt  <= '0;
      cnvReg  <= 1'b0;
      sclkReg <= 1'b0;
      busyReg <= 1'b0;
    end else begin
      state   <= stateNxt;
      tmr     <= tmrNxt;
      bitCnt  <= bitCntNxt;
      cnvReg  <= cnvNxt;
      sclkReg <= sclkNxt;
      busyReg <= busyNxt;
    end
  end

  assign cnvOut  = cnvReg;
  assign sclkOut = sclkReg;
  assign busy    = busyReg;

  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && startReq) |=> (cnvReg && busyReg));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busyReg |-> (!cnvReg && !sclkReg));

  // R4
  sclk_in_shift_chk: assert property (@(posedge clk) disable iff (rst)
    sclkReg |-> (state == ST_SHIFT));

  // R3
  settle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cnvReg) |-> !sclkReg);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busyReg && !strb.finish) |=> busyReg);

endmodule

// File: rtl/adcrd_dp.sv
module adcrd_dp
  import adcrd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdoIn,
  input  dpStrobe_t         strb,
  output logic              done,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= strb.finish;
      if (strb.capMsb) begin
        shreg <= {{(DATA_W-1){1'b0}}, sdoIn};
      end else if (strb.capBit) begin
        shreg <= {shreg[DATA_W-2:0], sdoIn};
      end
      if (strb.finish) begin
        result <= {shreg[DATA_W-2:0], sdoIn};
      end
    end
  end

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  msb_capture_chk: assert property (@(posedge clk) disable iff (rst)
    strb.capMsb |=> (shreg[0] == $past(sdoIn)));

endmodule

// File: rtl/adcrd_host.sv
module adcrd_host
  import adcrd_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CONV_CYC   = 400,
  parameter int SETTLE_CYC = 2,
  parameter int HALF_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startReq,
  input  logic              sdoIn,
  output logic              cnvOut,
  output logic              sclkOut,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);

  dpStrobe_t strb;

  adcrd_ctrl #(
    .DATA_W    (DATA_W),
    .CONV_CYC  (CONV_CYC),
    .SETTLE_CYC(SETTLE_CYC),
    .HALF_CYC  (HALF_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .startReq(startReq),
    .cnvOut  (cnvOut),
    .sclkOut (sclkOut),
    .busy    (busy),
    .strb    (strb)
  );

  adcrd_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk   (clk),
    .rst   (rst),
    .sdoIn (sdoIn),
    .strb  (strb),
    .done  (done),
    .result(result)
  );

  // R6
  busy_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R6
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

// File: tb/tb_adcrd_host.sv
module tb_adcrd_host;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 6;
  localparam int CONV       = 5;
  localparam int SETTLE     = 2;
  localparam int HALF       = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         startReq = 1'b0;
  logic         sdoIn = 1'b0;
  logic         cnvOut, sclkOut, busy, done;
  logic [W-1:0] result;

  logic [W-1:0] tbWord = '0;
  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  int cnvRises = 0;

  // monitor state
  logic prevCnv = 1'b0, prevSclk = 1'b0, prevDone = 1'b0;
  int cnvRun = 0, gapRun = 0, highRun = 0, lowRun = 0, pulses = 0, idx = 0;
  bit inGap = 1'b0;

  adcrd_host #(
    .DATA_W(W), .CONV_CYC(CONV), .SETTLE_CYC(SETTLE), .HALF_CYC(HALF)
  ) dut (
    .clk(clk), .rst(rst), .startReq(startReq), .sdoIn(sdoIn),
    .cnvOut(cnvOut), .sclkOut(sclkOut), .busy(busy), .done(done),
    .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // converter model and timing monitor, both at the falling system clock edge
  always @(negedge clk) begin
    if (rst) begin
      prevCnv = 1'b0; prevSclk = 1'b0; prevDone = 1'b0;
      cnvRun = 0; gapRun = 0; highRun = 0; lowRun = 0; pulses = 0;
      inGap = 1'b0;
    end else begin
      // converter: high impedance stand-in during conversion, MSB on fall
      if (cnvOut && !prevCnv) begin
        sdoIn = 1'b0;
        cnvRises++;
      end
      if (!cnvOut && prevCnv) begin
        sdoIn = tbWord[W-1];
        idx = W - 2;
      end
      if (!sclkOut && prevSclk && idx >= 0) begin
        sdoIn = tbWord[idx];
        idx--;
      end
      // R2: convert-high length
      if (cnvOut) cnvRun++;
      else if (prevCnv) begin
        check(cnvRun == CONV, "R2 convert high cycles", cnvRun, CONV);
        cnvRun = 0; gapRun = 0; inGap = 1'b1; pulses = 0;
      end
      // R3: settle gap
      if (inGap) begin
        if (sclkOut) begin
          check(gapRun == SETTLE, "R3 settle low cycles", gapRun, SETTLE);
          inGap = 1'b0;
        end else gapRun++;
      end
      // R4: pulse widths
      if (sclkOut) begin
        if (!prevSclk) begin
          pulses++;
          if (pulses > 1) check(lowRun == HALF, "R4 sclk low width", lowRun, HALF);
          highRun = 0;
        end
        highRun++;
      end else begin
        if (prevSclk) begin
          check(highRun == HALF, "R4 sclk high width", highRun, HALF);
          lowRun = 0;
        end
        lowRun++;
      end
      // R4 / R5 / R6 at done
      if (done) begin
        check(pulses == W - 1, "R4 pulse count", pulses, W - 1);
        check(result == tbWord, "R5 result word", int'(result), int'(tbWord));
        check(!busy, "R6 busy low with done", int'(busy), 0);
      end
      if (done && prevDone) check(1'b0, "R6 done longer than one cycle", 2, 1);
      // R8: quiet outside busy
      if (!busy && (cnvOut || sclkOut))
        check(1'b0, "R8 activity while not busy", int'({cnvOut, sclkOut}), 0);
      prevCnv = cnvOut; prevSclk = sclkOut; prevDone = done;
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      check(1'b0, "watchdog (all requirements)", cycles, 0);
      finishRun();
    end
  end

  task automatic waitDone(input string req);
    int waitCnt = 0;
    while (!done && waitCnt < 400) begin
      @(negedge clk);
      waitCnt++;
    end
    check(done, req, int'(done), 1);
  endtask

  task automatic runConv(input logic [W-1:0] w);
    tbWord = w;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(cnvOut && busy, "R2 convert and busy after start", int'({cnvOut, busy}), 3);
    waitDone("R6 done arrives");
    @(negedge clk);
    check(!done, "R6 done one cycle", int'(done), 0);
    check(result == w, "R6 result held", int'(result), int'(w));
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int risesBefore;
    @(negedge clk);
    doReset();
    // R1
    check(!cnvOut && !sclkOut && !busy && !done, "R1 outputs after reset",
          int'({cnvOut, sclkOut, busy, done}), 0);
    check(result == '0, "R1 result after reset", int'(result), 0);

    // R5: every code
    for (int c = 0; c < (1 << W); c++) begin
      runConv(W'(c));
      repeat (c % 3) @(negedge clk);
    end

    // R7: starts during conversion and during shift are ignored
    risesBefore = cnvRises;
    tbWord = 6'b101101;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (2) @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (9) @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitDone("R7 done after ignored starts");
    check(result == 6'b101101, "R7 result unaffected", int'(result), 45);
    @(negedge clk);
    check(cnvRises == risesBefore + 1, "R7 single convert rise", cnvRises - risesBefore, 1);

    // R8: idle stays quiet, long gap then convert
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check(!cnvOut && !sclkOut, "R8 idle after readout", int'({cnvOut, sclkOut}), 0);
    end
    repeat (2000) @(negedge clk);
    check(cnvRises == risesBefore + 1, "R8 no convert without start", cnvRises - risesBefore, 1);
    runConv(6'b010011);

    // R9: reset in the middle of a shift
    tbWord = 6'b110110;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (14) @(negedge clk);
    check(busy, "R9 busy before reset", int'(busy), 1);
    doReset();
    check(!cnvOut && !sclkOut && !busy && !done, "R9 outputs after mid reset",
          int'({cnvOut, sclkOut, busy, done}), 0);
    check(result == '0, "R9 result cleared", int'(result), 0);
    runConv(6'b100001);
    runConv(6'b011110);

    finishRun();
  end

endmodule